// File: doc/BRIEF.md
# Nibble-wide Ethernet CRC-32 engine

This block computes the 32-bit Ethernet frame check sequence four bits per clock, which matches the nibble width of a media-independent PHY data path. The enclosing MAC logic presets the remainder with `clear`. It then raises `enable` for every nibble that the CRC covers: the destination address, source address, type/length, data and pad. Preamble and start delimiter nibbles are never presented. The running remainder is visible on `crcOut` at all times.

To transmit, the MAC holds `fcsShift` for eight clocks. On each of those clocks `fcsNibble` carries the next ones-complemented remainder nibble in wire order, and `fcsDone` pulses once after the last nibble. To receive, the MAC keeps `enable` asserted through the four FCS bytes as well. `match` is then high exactly when the remainder has reached the fixed good-frame residue.

Top module: `crc32_nibble_engine`

## Requirements
- R1: After reset, and on the clock after `clear`, `crcOut` is 0xFFFFFFFF, `fcsDone` is 0 and the FCS nibble counter is empty.
- R2: `clear` wins over `enable` and `fcsShift` in the same cycle. The remainder becomes 0xFFFFFFFF and no shift or update takes effect.
- R3: On each clock with `enable` high (and no `clear` or `fcsShift`), the remainder advances by one nibble of `dataIn`. Bit 0 is processed first and bit 3 last, using the polynomial 0x04C11DB7 with the x31 term held in `crcOut[31]`. Per bit, feedback = `crcOut[31]` XOR the data bit, the register shifts left by one, and it is XORed with the polynomial when feedback is 1.
- R4: On a clock with `clear`, `enable` and `fcsShift` all low, `crcOut` holds its value.
- R5: `fcsNibble[i]` is the complement of `crcOut[31-i]` for i = 0..3. Each accepted shift moves `crcOut` left by four bits and fills the low nibble with ones. As a result, eight shifts present the complemented remainder in the order x31, x30, ..., x0, with each nibble's bit 0 sent first.
- R6: After a clear, only the first eight `fcsShift` clocks are accepted. `fcsDone` is high for exactly the one cycle after the eighth shift, and later `fcsShift` clocks leave `crcOut` unchanged until the next `clear`.
- R7: `match` is high exactly when `crcOut` equals 0xC704DD7B. Running the CRC over a frame followed by its own FCS nibbles gives this value.
- R8: A frame with a corrupted bit, followed by the FCS of the uncorrupted frame, leaves `match` low.
- R9: For the ASCII bytes "123456789" fed low nibble first, the bit-reversed complement of `crcOut` is 0xCBF43926.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one nibble per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Preset remainder and FCS counter |
| enable | input | 1 | Fold `dataIn` into the remainder |
| dataIn | input | 4 | Frame nibble, bit 0 first on the wire |
| fcsShift | input | 1 | Emit one FCS nibble this clock |
| crcOut | output | 32 | Running remainder, x31 in bit 31 |
| fcsNibble | output | 4 | Current FCS nibble in wire order |
| fcsDone | output | 1 | One-cycle pulse after the eighth FCS nibble |
| match | output | 1 | Remainder equals the good-frame residue |

## Verification
Any wrong bit in the remainder shows on `crcOut` one clock after the nibble that caused it, and it spreads through every later value. `match` and the eight FCS nibbles are also wrong then. A wrong FCS counter shows as `fcsDone` arriving early or late, or as a ninth shift that moves the remainder. The bench compares every cycle against a bit-serial model and against the standard check value, so the error is caught in the cycle where it first appears.

// File: rtl/crc_nib_pkg.sv
package crc_nib_pkg;
  typedef struct packed {
    logic seed;
    logic advance;
    logic shift;
  } crcCtrl_t;
endpackage

// File: rtl/crc32_nibble_ctrl.sv
module crc32_nibble_ctrl
  import crc_nib_pkg::*;
#(
  parameter int FCS_NIB = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     clear,
  input  logic     enable,
  input  logic     fcsShift,
  output crcCtrl_t ctl,
  output logic     fcsDone
);
  localparam int CNT_W = $clog2(FCS_NIB + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FCS_NIB - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FCS_NIB);

  logic [CNT_W-1:0] shiftCnt;
  logic             shiftOk;

  assign shiftOk     = (shiftCnt != FULL);
  assign ctl.seed    = clear;
  assign ctl.shift   = !clear && fcsShift && shiftOk;
  assign ctl.advance = !clear && !fcsShift && enable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftCnt <= '0;
      fcsDone  <= 1'b0;
    end else if (clear) begin
      shiftCnt <= '0;
      fcsDone  <= 1'b0;
    end else begin
      fcsDone <= ctl.shift && (shiftCnt == LAST);
      if (ctl.shift) shiftCnt <= shiftCnt + 1'b1;
    end
  end

  // R2: clear blocks both the update and the shift strobe
  p_clear_prio_r2: assert property (@(posedge clk) disable iff (!rstN)
    clear |-> (!ctl.advance && !ctl.shift));
  // R6: done is a single-cycle pulse
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    fcsDone |=> !fcsDone);
  // R6: counter never runs past the FCS length
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    shiftCnt <= FULL);
  // R6: shifting stops once all nibbles are out
  p_no_extra_r6: assert property (@(posedge clk) disable iff (!rstN)
    (shiftCnt == FULL) |-> !ctl.shift);
endmodule

// File: rtl/crc32_nibble_dp.sv
module crc32_nibble_dp
  import crc_nib_pkg::*;
#(
  parameter int               CRC_W = 32,
  parameter int               NIB_W = 4,
  parameter logic [CRC_W-1:0] POLY  = 32'h04C1_1DB7,
  parameter logic [CRC_W-1:0] SEED  = 32'hFFFF_FFFF
) (
  input  logic             clk,
  input  logic             rstN,
  input  crcCtrl_t         ctl,
  input  logic [NIB_W-1:0] dataIn,
  output logic [CRC_W-1:0] crcOut,
  output logic [NIB_W-1:0] fcsNibble
);
  logic [CRC_W-1:0] crcReg;

  function automatic logic [CRC_W-1:0] stepNib(input logic [CRC_W-1:0] cur,
                                               input logic [NIB_W-1:0] nib);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = cur;
    for (int b = 0; b < NIB_W; b++) begin
      fb = r[CRC_W-1] ^ nib[b];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ POLY;
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            crcReg <= SEED;
    else if (ctl.seed)    crcReg <= SEED;
    else if (ctl.shift)   crcReg <= {crcReg[CRC_W-NIB_W-1:0], {NIB_W{1'b1}}};
    else if (ctl.advance) crcReg <= stepNib(crcReg, dataIn);
  end

  generate
    for (genvar i = 0; i < NIB_W; i++) begin : g_wire
      assign fcsNibble[i] = ~crcReg[CRC_W-1-i];
    end
  endgenerate

  assign crcOut = crcReg;

  // R1: seeding loads the all-ones preset
  p_seed_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.seed |=> (crcReg == SEED));
  // R4: no strobe means no change
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.seed && !ctl.shift && !ctl.advance) |=> $stable(crcReg));
  // R5: each shift refills the low nibble with ones
  p_fill_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shift |=> (crcReg[NIB_W-1:0] == {NIB_W{1'b1}}));
endmodule

// File: rtl/crc32_nibble_engine.sv
module crc32_nibble_engine
  import crc_nib_pkg::*;
#(
  parameter int               CRC_W   = 32,
  parameter int               NIB_W   = 4,
  parameter logic [CRC_W-1:0] POLY    = 32'h04C1_1DB7,
  parameter logic [CRC_W-1:0] SEED    = 32'hFFFF_FFFF,
  parameter logic [CRC_W-1:0] RESIDUE = 32'hC704_DD7B
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             enable,
  input  logic [NIB_W-1:0] dataIn,
  input  logic             fcsShift,
  output logic [CRC_W-1:0] crcOut,
  output logic [NIB_W-1:0] fcsNibble,
  output logic             fcsDone,
  output logic             match
);
  localparam int FCS_NIB = CRC_W / NIB_W;

  crcCtrl_t ctl;

  crc32_nibble_ctrl #(.FCS_NIB(FCS_NIB)) uCtrl (
    .clk(clk), .rstN(rstN), .clear(clear), .enable(enable),
    .fcsShift(fcsShift), .ctl(ctl), .fcsDone(fcsDone)
  );

  crc32_nibble_dp #(.CRC_W(CRC_W), .NIB_W(NIB_W), .POLY(POLY), .SEED(SEED)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dataIn(dataIn),
    .crcOut(crcOut), .fcsNibble(fcsNibble)
  );

  assign match = (crcOut == RESIDUE);

  // R6: after the last nibble the remainder is fully replaced by fill
  p_done_fill_r6: assert property (@(posedge clk) disable iff (!rstN)
    fcsDone |-> (crcOut == {CRC_W{1'b1}}));
  // R7: a fully shifted-out register never reads as a good residue
  p_done_nomatch_r7: assert property (@(posedge clk) disable iff (!rstN)
    fcsDone |-> !match);
endmodule

// File: tb/crc32_nibble_engine_test.sv
module crc32_nibble_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] POLY = 32'h04C1_1DB7;
  localparam logic [31:0] RES  = 32'hC704_DD7B;

  logic clk = 1'b0, rstN = 1'b0, clear = 1'b0, enable = 1'b0, fcsShift = 1'b0;
  logic [3:0] dataIn = '0;
  logic [31:0] crcOut;
  logic [3:0] fcsNibble;
  logic fcsDone, match;

  crc32_nibble_engine uut (
    .clk(clk), .rstN(rstN), .clear(clear), .enable(enable), .dataIn(dataIn),
    .fcsShift(fcsShift), .crcOut(crcOut), .fcsNibble(fcsNibble),
    .fcsDone(fcsDone), .match(match)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    string       tag;
    logic [31:0] crc;
    logic        done;
    logic        mat;
  } item_t;

  item_t       expQ[$];
  int          checks = 0, errors = 0;
  logic [31:0] model = 32'hFFFF_FFFF;
  int          benchCnt = 0;
  bit          finished = 0;

  function automatic logic [31:0] refStep(input logic [31:0] c, input logic [3:0] n);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 4; b++) begin
      if (r[31] ^ n[b]) r = {r[30:0], 1'b0} ^ POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [31:0] bitRev(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one operation per clock, expectation pushed for the monitor
  task automatic op(input string tag, input logic clr, input logic en,
                    input logic [3:0] d, input logic sh);
    item_t it;
    logic  doneExp;
    @(negedge clk);
    clear = clr; enable = en; dataIn = d; fcsShift = sh;
    doneExp = 1'b0;
    if (clr) begin
      model = 32'hFFFF_FFFF; benchCnt = 0;
    end else if (sh) begin
      if (benchCnt < 8) begin
        #1;
        check({tag, " R5 nibble"}, {28'd0, fcsNibble},
              {28'd0, ~model[28], ~model[29], ~model[30], ~model[31]});
        model = {model[27:0], 4'hF};
        benchCnt++;
        doneExp = (benchCnt == 8);
      end
    end else if (en) begin
      model = refStep(model, d);
    end
    it.tag = tag; it.crc = model; it.done = doneExp; it.mat = (model == RES);
    expQ.push_back(it);
    @(posedge clk);
    #2;
    clear = 0; enable = 0; fcsShift = 0; dataIn = '0;
  endtask

  task automatic feedByte(input string tag, input logic [7:0] b);
    op(tag, 0, 1, b[3:0], 0);
    op(tag, 0, 1, b[7:4], 0);
  endtask

  // monitor: compare after each clock edge
  always begin
    item_t it;
    @(posedge clk);
    #1;
    if (expQ.size() > 0) begin
      it = expQ.pop_front();
      check({it.tag, " crcOut"}, crcOut, it.crc);
      check({it.tag, " fcsDone"}, {31'd0, fcsDone}, {31'd0, it.done});
      check({it.tag, " match R7"}, {31'd0, match}, {31'd0, it.mat});
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0]  fcsN [8];
    logic [31:0] goodRem;
    string       digits;
    digits = "123456789";
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset crc", crcOut, 32'hFFFF_FFFF);
    check("R1 reset done", {31'd0, fcsDone}, 32'd0);
    check("R1 reset match", {31'd0, match}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 / R9: standard check string
    for (int i = 0; i < 9; i++) feedByte("R3 digits", digits[i]);
    @(negedge clk);
    check("R9 check value", bitRev(~crcOut), 32'hCBF4_3926);

    // R4: idle clocks hold
    op("R4 hold", 0, 0, 4'hA, 0);
    op("R4 hold", 0, 0, 4'h5, 0);

    // R5 / R6: shift out, then an extra shift that must be ignored
    for (int k = 0; k < 8; k++) op("R6 shift", 0, 0, 4'h0, 1);
    op("R6 extra shift", 0, 0, 4'h0, 1);
    op("R6 extra shift", 0, 1, 4'h3, 1);

    // R2: clear with everything else asserted
    op("R2 clear prio", 1, 1, 4'h7, 1);
    op("R3 after clear", 0, 1, 4'hC, 0);
    op("R1 clear", 1, 0, 4'h0, 0);

    // R7: frame plus its own FCS
    for (int i = 0; i < 24; i++) feedByte("R3 frame", 8'((i * 37) ^ 8'h5A));
    goodRem = model;
    for (int k = 0; k < 8; k++)
      fcsN[k] = {~goodRem[28-4*k], ~goodRem[29-4*k], ~goodRem[30-4*k], ~goodRem[31-4*k]};
    for (int k = 0; k < 8; k++) op("R7 fcs", 0, 1, fcsN[k], 0);
    @(negedge clk);
    check("R7 good frame match", {31'd0, match}, 32'd1);
    check("R7 residue", crcOut, RES);

    // R8: corrupted frame with original FCS
    op("R8 clear", 1, 0, 4'h0, 0);
    for (int i = 0; i < 24; i++)
      feedByte("R8 frame", 8'((i * 37) ^ 8'h5A) ^ ((i == 9) ? 8'h04 : 8'h00));
    for (int k = 0; k < 8; k++) op("R8 fcs", 0, 1, fcsN[k], 0);
    @(negedge clk);
    check("R8 bad frame match", {31'd0, match}, 32'd0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule